// File: doc/BRIEF.md
# DPLL Lock Status Qualifier

This block decides, for two digital PLL paths, whether each one may be reported as locked. One path is the main path and the other is the auxiliary path. For each path the block receives the results of the phase comparison and the frequency-range check as level inputs: coarse phase loss, fine phase loss and a frequency hard alarm. It also watches the selected input clock of each path directly, with a missing-edge detector that runs on the reference clock. Each loss source has its own enable bit, and only enabled sources can hold a path out of lock.

A path becomes locked only after a qualification window passes with no enabled loss source active. The window is measured in strobes of a prescaled tick, and `WIN_TICKS` strobes make up the two-second window. Any enabled loss event drops lock on the next clock and restarts the window from zero. On the auxiliary path, fast loss always counts, whatever the fast-loss switch holds. Every lock change on the auxiliary path sets a sticky status flag. That flag raises the interrupt request when the interrupt enable is 1, and a write-one-to-clear pulse clears it.

All control and status pins are plain levels or single-cycle strobes. The block has no streaming interface, so it has no back-pressure rules.

Top module: `dpll_lock_qual`

## Requirements
- R1: Fast loss on a path asserts when no synchronized rising edge of that path's input clock has been seen for more than 2*`exp_period`+`MARGIN` reference cycles, which is two missed input periods plus a margin. It clears on the next rising edge.
- R2: On the main path, fast loss unlocks the path only while `fast_sw` is 1. On the auxiliary path, fast loss always unlocks the path.
- R3: Coarse phase loss, fine phase loss and the frequency hard alarm each unlock a path only while their own enable (`coarse_en`, `fine_en`, `hard_en`) is 1. The same enable applies to both paths.
- R4: An enabled loss event seen in a cycle makes that path's lock output 0 on the next clock edge. It also restarts the path's qualification count from zero.
- R5: A path's lock output rises at the edge that samples the `WIN_TICKS`-th `tick` strobe counted since the last enabled loss event. After `WIN_TICKS`-1 strobes it is still 0. With every enable at 0 and clocks running, both paths lock after `WIN_TICKS` strobes.
- R6: `aux_sts` is set at the same edge at which `aux_lock` changes, in either direction. A change of `main_lock` alone does not set it.
- R7: A one-cycle `sts_clr` pulse clears `aux_sts`. If an auxiliary lock change occurs in the same cycle, the flag stays set.
- R8: `irq` is 1 exactly when `aux_sts` is 1 and `irq_en` is 1.
- R9: After reset both lock outputs are 0, `aux_sts` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled qualification strobe, one cycle wide |
| main_ref_in | input | 1 | Selected input clock of the main path (asynchronous) |
| aux_ref_in | input | 1 | Selected input clock of the auxiliary path (asynchronous) |
| exp_period | input | PERIOD_W | Expected input period in reference cycles |
| fast_sw | input | 1 | Fast-loss enable, main path only |
| coarse_en | input | 1 | Coarse phase loss enable |
| fine_en | input | 1 | Fine phase loss enable |
| hard_en | input | 1 | Frequency hard alarm enable |
| main_coarse | input | 1 | Main path coarse phase loss level |
| main_fine | input | 1 | Main path fine phase loss level |
| main_hard | input | 1 | Main path frequency hard alarm level |
| aux_coarse | input | 1 | Auxiliary path coarse phase loss level |
| aux_fine | input | 1 | Auxiliary path fine phase loss level |
| aux_hard | input | 1 | Auxiliary path frequency hard alarm level |
| irq_en | input | 1 | Interrupt enable for the auxiliary status flag |
| sts_clr | input | 1 | Write-one-to-clear pulse for `aux_sts` |
| main_lock | output | 1 | Main path locked |
| aux_lock | output | 1 | Auxiliary path locked |
| aux_sts | output | 1 | Sticky auxiliary lock-change flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a lock change on the auxiliary path in the same cycle as a clear pulse. To get there, the path must first be qualified through the full tick window. The bench then raises an enabled auxiliary loss event and `sts_clr` on the same falling edge. The fast-loss behaviour has no direct output of its own. The bench reaches it by stopping the generated input clocks long enough to exceed the gap threshold, with each path already locked, and it checks that lock survives a short gap.

// File: rtl/dlq_pkg.sv
package dlq_pkg;

  localparam int unsigned PATH_MAIN = 0;
  localparam int unsigned PATH_AUX  = 1;
  localparam int unsigned NUM_PATHS = 2;

  // One bit per loss source, also used for the matching enables.
  typedef struct packed {
    logic fast;
    logic coarse;
    logic fine;
    logic hard;
  } loss_vec_t;

  function automatic logic any_gated(input loss_vec_t ev, input loss_vec_t en);
    return |(ev & en);
  endfunction

endpackage

// File: rtl/dlq_edge_watch.sv
// Missing-edge detector: counts reference cycles since the last
// synchronized rising edge of an asynchronous input clock.
module dlq_edge_watch #(
  parameter int unsigned PERIOD_W = 8,
  parameter int unsigned MARGIN   = 2,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sig_in,
  input  logic [PERIOD_W-1:0] exp_period,
  output logic                loss
);

  localparam int unsigned GAP_W = PERIOD_W + 2;

  logic [SYNC_N:0]  sync_q;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] limit;
  logic             rise;

  // The last synchronizer stage is kept one extra cycle for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], sig_in};
  end

  assign rise  = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
  assign limit = GAP_W'({exp_period, 1'b0}) + GAP_W'(MARGIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             gap_q <= '0;
    else if (rise)          gap_q <= '0;
    else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
  end

  assign loss = (gap_q > limit);

endmodule

// File: rtl/dlq_qual_timer.sv
// Qualification window: lock only after WIN_TICKS strobes with no
// enabled loss event; any enabled event unlocks and restarts.
module dlq_qual_timer #(
  parameter int unsigned WIN_TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bad,
  output logic lock,
  output logic toggle
);

  localparam int unsigned TW = (WIN_TICKS < 2) ? 1 : $clog2(WIN_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(WIN_TICKS - 1);
  localparam logic [TW-1:0] FULL = TW'(WIN_TICKS);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          lock_q, lock_d;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (bad) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (tick && !lock_q) begin
      if (cnt_q == LAST) begin
        cnt_d  = FULL;
        lock_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign lock   = lock_q;
  assign toggle = lock_d ^ lock_q;

endmodule

// File: rtl/dlq_sts_flag.sv
// Sticky change flag with write-one-to-clear; a set wins over a clear.
module dlq_sts_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic sts,
  output logic irq
);

  logic sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sts_q <= 1'b0;
    else if (set) sts_q <= 1'b1;
    else if (clr) sts_q <= 1'b0;
  end

  assign sts = sts_q;
  assign irq = sts_q & irq_en;

endmodule

// File: rtl/dpll_lock_qual.sv
module dpll_lock_qual
  import dlq_pkg::*;
#(
  parameter int unsigned PERIOD_W  = 8,
  parameter int unsigned MARGIN    = 2,
  parameter int unsigned WIN_TICKS = 2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                main_ref_in,
  input  logic                aux_ref_in,
  input  logic [PERIOD_W-1:0] exp_period,
  input  logic                fast_sw,
  input  logic                coarse_en,
  input  logic                fine_en,
  input  logic                hard_en,
  input  logic                main_coarse,
  input  logic                main_fine,
  input  logic                main_hard,
  input  logic                aux_coarse,
  input  logic                aux_fine,
  input  logic                aux_hard,
  input  logic                irq_en,
  input  logic                sts_clr,
  output logic                main_lock,
  output logic                aux_lock,
  output logic                aux_sts,
  output logic                irq
);

  logic      [NUM_PATHS-1:0] ref_in;
  logic      [NUM_PATHS-1:0] fl;
  logic      [NUM_PATHS-1:0] lock_v;
  logic      [NUM_PATHS-1:0] tog_v;
  logic      [NUM_PATHS-1:0] bad_v;
  loss_vec_t                 ev_v [NUM_PATHS];
  loss_vec_t                 en_v [NUM_PATHS];
  loss_vec_t                 lvl_main, lvl_aux;

  assign ref_in[PATH_MAIN] = main_ref_in;
  assign ref_in[PATH_AUX]  = aux_ref_in;

  assign lvl_main = '{fast: 1'b0, coarse: main_coarse, fine: main_fine, hard: main_hard};
  assign lvl_aux  = '{fast: 1'b0, coarse: aux_coarse,  fine: aux_fine,  hard: aux_hard};

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    dlq_edge_watch #(
      .PERIOD_W (PERIOD_W),
      .MARGIN   (MARGIN)
    ) u_watch (
      .clk        (clk),
      .rst_n      (rst_n),
      .sig_in     (ref_in[g]),
      .exp_period (exp_period),
      .loss       (fl[g])
    );

    always_comb begin
      ev_v[g]      = (g == PATH_AUX) ? lvl_aux : lvl_main;
      ev_v[g].fast = fl[g];
      en_v[g].coarse = coarse_en;
      en_v[g].fine   = fine_en;
      en_v[g].hard   = hard_en;
      if (g == PATH_AUX) en_v[g].fast = 1'b1;
      else               en_v[g].fast = fast_sw;
    end

    assign bad_v[g] = any_gated(ev_v[g], en_v[g]);

    dlq_qual_timer #(
      .WIN_TICKS (WIN_TICKS)
    ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .bad    (bad_v[g]),
      .lock   (lock_v[g]),
      .toggle (tog_v[g])
    );
  end

  dlq_sts_flag u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (tog_v[PATH_AUX]),
    .clr    (sts_clr),
    .irq_en (irq_en),
    .sts    (aux_sts),
    .irq    (irq)
  );

  assign main_lock = lock_v[PATH_MAIN];
  assign aux_lock  = lock_v[PATH_AUX];

endmodule

// File: rtl/dlq_checker.sv
module dlq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       fast_sw,
  input logic       coarse_en,
  input logic       hard_en,
  input logic       main_coarse,
  input logic       aux_hard,
  input logic       irq_en,
  input logic       sts_clr,
  input logic [1:0] fl,
  input logic       main_lock,
  input logic       aux_lock,
  input logic       aux_sts,
  input logic       irq
);

  a_r2_aux_fast_always: assert property (@(posedge clk) disable iff (!rst_n)
    fl[1] |=> !aux_lock);

  a_r2_main_fast_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (fl[0] && fast_sw) |=> !main_lock);

  a_r3_main_coarse: assert property (@(posedge clk) disable iff (!rst_n)
    (main_coarse && coarse_en) |=> !main_lock);

  a_r3_aux_hard: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_hard && hard_en) |=> !aux_lock);

  a_r5_lock_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_lock) |-> $past(tick));

  a_r6_sts_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_lock != $past(aux_lock)) |-> aux_sts);

  a_r6_sts_only_aux: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_sts) |-> (aux_lock != $past(aux_lock)));

  a_r7_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aux_sts) |-> $past(sts_clr));

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && aux_sts));

endmodule

bind dpll_lock_qual dlq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .fast_sw     (fast_sw),
  .coarse_en   (coarse_en),
  .hard_en     (hard_en),
  .main_coarse (main_coarse),
  .aux_hard    (aux_hard),
  .irq_en      (irq_en),
  .sts_clr     (sts_clr),
  .fl          (fl),
  .main_lock   (main_lock),
  .aux_lock    (aux_lock),
  .aux_sts     (aux_sts),
  .irq         (irq)
);

// File: tb/tb_dpll_lock_qual.sv
`timescale 1ns/1ps
module tb_dpll_lock_qual;

  localparam int PW  = 8;
  localparam int MG  = 2;
  localparam int WIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, main_ref_in = 0, aux_ref_in = 0;
  logic [PW-1:0] exp_period = 8'd4;
  logic fast_sw = 0, coarse_en = 0, fine_en = 0, hard_en = 0;
  logic main_coarse = 0, main_fine = 0, main_hard = 0;
  logic aux_coarse = 0, aux_fine = 0, aux_hard = 0;
  logic irq_en = 0, sts_clr = 0;
  logic main_lock, aux_lock, aux_sts, irq;

  logic run_main = 0, run_aux = 0;
  int   ph = 0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  dpll_lock_qual #(.PERIOD_W(PW), .MARGIN(MG), .WIN_TICKS(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .main_ref_in(main_ref_in), .aux_ref_in(aux_ref_in), .exp_period(exp_period),
    .fast_sw(fast_sw), .coarse_en(coarse_en), .fine_en(fine_en), .hard_en(hard_en),
    .main_coarse(main_coarse), .main_fine(main_fine), .main_hard(main_hard),
    .aux_coarse(aux_coarse), .aux_fine(aux_fine), .aux_hard(aux_hard),
    .irq_en(irq_en), .sts_clr(sts_clr),
    .main_lock(main_lock), .aux_lock(aux_lock), .aux_sts(aux_sts), .irq(irq));

  // Input clocks: period 4 reference cycles, held low when stopped.
  always @(negedge clk) begin
    ph = (ph + 1) % 2;
    if (!run_main)    main_ref_in = 1'b0;
    else if (ph == 0) main_ref_in = ~main_ref_in;
    if (!run_aux)     aux_ref_in = 1'b0;
    else if (ph == 0) aux_ref_in = ~aux_ref_in;
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic clear_sts();
    @(negedge clk) sts_clr = 1'b1;
    @(negedge clk) sts_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(main_lock, 1'b0, "R9 main_lock after reset");
    chk(aux_lock,  1'b0, "R9 aux_lock after reset");
    chk(aux_sts,   1'b0, "R9 aux_sts after reset");
    chk(irq,       1'b0, "R9 irq after reset");
    rst_n = 1'b1;
    run_main = 1; run_aux = 1;
    repeat (8) @(negedge clk);

    // R5: all enables 0, lock after exactly WIN strobes
    ticks(WIN - 1);
    chk(main_lock, 1'b0, "R5 main not locked at WIN-1");
    chk(aux_lock,  1'b0, "R5 aux not locked at WIN-1");
    ticks(1);
    chk(main_lock, 1'b1, "R5 main locked at WIN");
    chk(aux_lock,  1'b1, "R5 aux locked at WIN");
    chk(aux_sts,   1'b1, "R6 sts set on aux lock rise");
    chk(irq,       1'b0, "R8 irq masked");
    @(negedge clk) irq_en = 1'b1;
    #1 chk(irq, 1'b1, "R8 irq when enabled");
    clear_sts();
    chk(aux_sts, 1'b0, "R7 clear pulse");
    chk(irq,     1'b0, "R8 irq follows cleared flag");

    // R3/R4: sweep every enable combination against each loss source
    for (int en = 0; en < 16; en++) begin
      for (int src = 0; src < 3; src++) begin
        logic en_bit;
        @(negedge clk);
        {fast_sw, coarse_en, fine_en, hard_en} = 4'(en);
        if (!main_lock || !aux_lock) ticks(WIN);
        clear_sts();
        en_bit = (src == 0) ? coarse_en : (src == 1) ? fine_en : hard_en;
        @(negedge clk);
        case (src)
          0: begin main_coarse = 1; aux_coarse = 1; end
          1: begin main_fine = 1;   aux_fine = 1;   end
          default: begin main_hard = 1; aux_hard = 1; end
        endcase
        @(negedge clk);
        {main_coarse, main_fine, main_hard, aux_coarse, aux_fine, aux_hard} = '0;
        chk(main_lock, !en_bit, $sformatf("R3 main en=%0d src=%0d", en, src));
        chk(aux_lock,  !en_bit, $sformatf("R3 aux en=%0d src=%0d", en, src));
        chk(aux_sts,   en_bit,  $sformatf("R6 sts en=%0d src=%0d", en, src));
      end
    end

    // R4: window restarts after an event part-way through
    @(negedge clk) {fast_sw, coarse_en, fine_en, hard_en} = 4'b0100;
    @(negedge clk) main_coarse = 1;
    @(negedge clk) main_coarse = 0;
    ticks(WIN - 1);
    @(negedge clk) main_coarse = 1;
    @(negedge clk) main_coarse = 0;
    ticks(WIN - 1);
    chk(main_lock, 1'b0, "R4 window restarted by event");
    ticks(1);
    chk(main_lock, 1'b1, "R4 lock after full clean window");

    // R1/R2: fast loss, main gated by fast_sw, aux always
    for (int fs = 0; fs < 2; fs++) begin
      @(negedge clk) fast_sw = fs[0];
      if (!main_lock || !aux_lock) ticks(WIN);
      chk(main_lock, 1'b1, "R1 main locked before gap");
      run_main = 0; run_aux = 0;
      repeat (4) @(negedge clk);
      chk(main_lock, 1'b1, "R1 main survives short gap");
      chk(aux_lock,  1'b1, "R1 aux survives short gap");
      repeat (16) @(negedge clk);
      chk(main_lock, fs == 0, $sformatf("R2 main fast loss fast_sw=%0d", fs));
      chk(aux_lock,  1'b0,    $sformatf("R2 aux fast loss fast_sw=%0d", fs));
      ticks(WIN);
      chk(aux_lock, 1'b0, "R4 no lock while clock absent");
      run_main = 1; run_aux = 1;
      repeat (8) @(negedge clk);
      ticks(WIN);
      chk(main_lock, 1'b1, "R1 main relocks after edges return");
      chk(aux_lock,  1'b1, "R1 aux relocks after edges return");
    end

    // R7: transition coincident with clear keeps the flag
    clear_sts();
    @(negedge clk) begin coarse_en = 1; aux_coarse = 1; sts_clr = 1; end
    @(negedge clk) begin aux_coarse = 0; sts_clr = 0; end
    chk(aux_lock, 1'b0, "R7 aux unlocked");
    chk(aux_sts,  1'b1, "R7 set wins over clear");
    chk(irq,      1'b1, "R8 irq from coincident set");

    // R6: main-only change leaves the flag alone
    ticks(WIN);
    clear_sts();
    @(negedge clk) main_hard = 1; hard_en = 1;
    @(negedge clk) main_hard = 0;
    chk(main_lock, 1'b0, "R6 main unlocked");
    chk(aux_sts,   1'b0, "R6 main change does not set flag");
    chk(irq,       1'b0, "R8 irq stays low");

    finish_run();
  end

endmodule